// File: doc/BRIEF.md
# Prescaled Single-Channel PWM Timer

This block drives one pulse-width-modulated output from two 32-bit registers on a small memory-mapped bus. The count register holds two 10-bit tick counts: the length of a full period and the length of the high part at the start of each period. The control register holds the channel enable, a hold bit that freezes timing updates, a general-purpose select bit, and a 5-bit exponent `e`. One timer tick lasts 2^e input clocks, and `e` is saturated at 24. Only normal polarity exists: the output is high in the opening part of each period. A zero period or a zero high length is refused, so a 0% output cannot be produced.

Software writes always land in programmed copies, and reads return those copies. The running timer uses a separate active set of period, high length and exponent. The programmed set is copied into the active set only while the hold bit is 0. If the channel is running, the copy waits for the end of the current period. If it is stopped, the copy happens on the cycle after the write. To change several values together, software sets the hold bit, rewrites the fields, and clears the hold bit. All three values then take effect at the same period boundary.

The sequencing is a four-state machine:
- IDLE: the enable bit is 0.
- BLOCKED: the channel is enabled but the active or pending timing holds a zero.
- HIGH and LOW: the two halves of a running period.

Its transitions are:
- Any state goes to IDLE when the enable bit is cleared.
- IDLE or BLOCKED goes to HIGH (start) when the next timing is valid, and otherwise to BLOCKED (refuse).
- HIGH goes to LOW when the tick count reaches the high length.
- LOW goes back to HIGH when the period wraps.
- HIGH or LOW goes to BLOCKED when a zero setting is loaded.

Top module: `pwm_timer`

## Requirements
- R1: After reset both registers read 0 and `pwm_out` is 0.
- R2: The control register is at byte offset 0x0. Its fields are: bit 0 enable, bit 4 select, bit 11 hold, bit 15 exponent bit 0, and bits 19:16 exponent bits 4:1. It reads back the last written values with all other bits 0, so writing all ones reads 0x000F8811.
- R3: The count register is at byte offset 0x4. Bits 25:16 hold the period and bits 9:0 hold the high length. It reads back the last written values with all other bits 0, so writing all ones reads 0x03FF03FF.
- R4: Take an enabled channel with period P, high length Q, 0 < Q < P, and exponent e. Its output is high for Q·2^e clocks and then low for (P−Q)·2^e clocks, repeating.
- R5: When Q ≥ P (both nonzero), the enabled output stays high.
- R6: With P = 0 or Q = 0 the output stays low even when enabled.
- R7: Clearing enable drives the output low by the second clock edge after the write. A later enable starts from the beginning of a period, so the first high run is a full Q·2^e clocks.
- R8: While the hold bit is 1, writes to period, high length or exponent do not change the waveform, but they do read back. After the hold bit is cleared, the new values take effect together at the next period boundary.
- R9: With the hold bit 0, a timing write made while the channel runs lets the current period finish with the old values. The new values apply from the next period.
- R10: Byte offsets other than 0x0 and 0x4 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | 1 | PWM output, normal polarity |

## Verification
The assertions assume the bus writes at most one register per cycle, with a single-cycle strobe and a stable address. They also assume the exponent is changed only through the register interface. The stimulus drives every access in a task that raises the strobe for exactly one cycle away from the clock edge. It keeps exponents at 2 or below, so that waveform sweeps over periods 1 to 5 and high lengths 1 to 6 finish quickly. The hold and boundary cases are set up by aligning writes to an observed rising edge of the output, so each update lands at a known point inside a period.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned DATA_W      = 32;
    localparam int unsigned FIELD_EXP_W = 5;

    // Byte offsets of the two registers
    localparam int unsigned CTRL_OFS = 0;
    localparam int unsigned CNT_OFS  = 4;

    // Control register field positions
    localparam int unsigned EN_BIT    = 0;
    localparam int unsigned SEL_BIT   = 4;
    localparam int unsigned HOLD_BIT  = 11;
    localparam int unsigned EXPLO_BIT = 15;
    localparam int unsigned EXPHI_LSB = 16;

    // Count register field positions
    localparam int unsigned PER_LSB = 16;
    localparam int unsigned HI_LSB  = 0;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_BLOCKED = 2'd1,
        ST_HIGH    = 2'd2,
        ST_LOW     = 2'd3
    } pwm_state_e;
endpackage

// File: rtl/pwm_timer_regs.sv
module pwm_timer_regs
    import pwm_timer_pkg::*;
#(
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned CNT_W   = 10,
    parameter int unsigned EXP_MAX = 24,
    localparam int unsigned EXP_W  = $clog2(EXP_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              running,
    input  logic              boundary,
    output logic              enable,
    output logic [CNT_W-1:0]  act_period,
    output logic [CNT_W-1:0]  act_high,
    output logic [EXP_W-1:0]  act_exp,
    output logic [CNT_W-1:0]  nxt_period,
    output logic [CNT_W-1:0]  nxt_high
);
    timeunit 1ns;
    timeprecision 1ps;

    logic                   en_q, sel_q, hold_q, pending_q;
    logic [FIELD_EXP_W-1:0] prog_exp;
    logic [CNT_W-1:0]       prog_period, prog_high;
    logic [EXP_W-1:0]       prog_exp_sat;
    logic                   wr_ctrl, wr_cnt, load;
    logic [3:0]             unused_wdata_bits;

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(CTRL_OFS));
    assign wr_cnt  = bus_wr && (bus_addr == ADDR_W'(CNT_OFS));
    assign unused_wdata_bits = {^bus_wdata[31:26], ^bus_wdata[14:12], bus_wdata[10], 1'b0};

    // Exponent values above the limit saturate to the limit
    always_comb begin
        if (32'(prog_exp) > EXP_MAX) prog_exp_sat = EXP_W'(EXP_MAX);
        else                         prog_exp_sat = EXP_W'(prog_exp);
    end

    // Programmed copies written by software
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q        <= 1'b0;
            sel_q       <= 1'b0;
            hold_q      <= 1'b0;
            prog_exp    <= '0;
            prog_period <= '0;
            prog_high   <= '0;
        end else begin
            if (wr_ctrl) begin
                en_q     <= bus_wdata[EN_BIT];
                sel_q    <= bus_wdata[SEL_BIT];
                hold_q   <= bus_wdata[HOLD_BIT];
                prog_exp <= {bus_wdata[EXPHI_LSB +: FIELD_EXP_W-1], bus_wdata[EXPLO_BIT]};
            end
            if (wr_cnt) begin
                prog_period <= bus_wdata[PER_LSB +: CNT_W];
                prog_high   <= bus_wdata[HI_LSB +: CNT_W];
            end
        end
    end

    // Transfer to the active set: never under hold, only at a period end while running
    assign load = pending_q && !hold_q && (!running || boundary);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_q  <= 1'b0;
            act_period <= '0;
            act_high   <= '0;
            act_exp    <= '0;
        end else begin
            if (wr_ctrl || wr_cnt) pending_q <= 1'b1;
            else if (load)         pending_q <= 1'b0;
            if (load) begin
                act_period <= prog_period;
                act_high   <= prog_high;
                act_exp    <= prog_exp_sat;
            end
        end
    end

    assign enable     = en_q;
    assign nxt_period = load ? prog_period : act_period;
    assign nxt_high   = load ? prog_high   : act_high;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(CTRL_OFS)) begin
            bus_rdata[EN_BIT]                       = en_q;
            bus_rdata[SEL_BIT]                      = sel_q;
            bus_rdata[HOLD_BIT]                     = hold_q;
            bus_rdata[EXPLO_BIT]                    = prog_exp[0];
            bus_rdata[EXPHI_LSB +: FIELD_EXP_W-1]   = prog_exp[FIELD_EXP_W-1:1];
        end else if (bus_addr == ADDR_W'(CNT_OFS)) begin
            bus_rdata[PER_LSB +: CNT_W] = prog_period;
            bus_rdata[HI_LSB +: CNT_W]  = prog_high;
        end
    end

    // R8: while the hold bit is set, the active timing cannot move
    a_r8_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |=> ($stable(act_period) && $stable(act_high) && $stable(act_exp)));

    // R9: a running channel only takes new timing at a period end
    a_r9_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !boundary) |=> ($stable(act_period) && $stable(act_high) && $stable(act_exp)));
endmodule

// File: rtl/pwm_timer_prescaler.sv
module pwm_timer_prescaler #(
    parameter int unsigned EXP_MAX = 24,
    localparam int unsigned EXP_W  = $clog2(EXP_MAX + 1),
    localparam int unsigned PRE_W  = (EXP_MAX > 0) ? EXP_MAX : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [EXP_W-1:0] exp_sel,
    output logic             tick
);
    timeunit 1ns;
    timeprecision 1ps;

    generate
        if (EXP_MAX == 0) begin : g_no_div
            logic unused_div_inputs;
            assign unused_div_inputs = clk ^ rst_n ^ (^exp_sel);
            assign tick = run;
        end else begin : g_div
            logic [PRE_W-1:0] pre_cnt;
            logic [PRE_W-1:0] limit;

            // Terminal count is 2^exp - 1
            assign limit = {PRE_W{1'b1}} >> (EXP_MAX - int'(exp_sel));
            assign tick  = run && (pre_cnt == limit);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)    pre_cnt <= '0;
                else if (!run) pre_cnt <= '0;
                else if (tick) pre_cnt <= '0;
                else           pre_cnt <= pre_cnt + PRE_W'(1);
            end

            // R4: the divider never runs past the selected terminal count
            a_r4_prescale_range: assert property (@(posedge clk) disable iff (!rst_n)
                pre_cnt <= limit);
        end
    endgenerate
endmodule

// File: rtl/pwm_timer_core.sv
module pwm_timer_core
    import pwm_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick,
    input  logic [CNT_W-1:0] act_period,
    input  logic [CNT_W-1:0] act_high,
    input  logic [CNT_W-1:0] nxt_period,
    input  logic [CNT_W-1:0] nxt_high,
    output logic             running,
    output logic             boundary,
    output logic             pwm_out
);
    timeunit 1ns;
    timeprecision 1ps;

    pwm_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             nxt_valid;

    assign nxt_valid = (nxt_period != '0) && (nxt_high != '0);
    assign running   = (state_q == ST_HIGH) || (state_q == ST_LOW);
    assign boundary  = running && tick && (cnt_q == act_period - CNT_W'(1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Tick counter within the period
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // Next state: stop, start, refuse, toggle halves, wrap
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!enable) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_BLOCKED: begin
                    cnt_d   = '0;
                    state_d = nxt_valid ? ST_HIGH : ST_BLOCKED;
                end
                ST_HIGH, ST_LOW: begin
                    if (!nxt_valid) begin
                        state_d = ST_BLOCKED;
                        cnt_d   = '0;
                    end else if (tick) begin
                        cnt_d   = boundary ? '0 : cnt_q + CNT_W'(1);
                        state_d = (cnt_d < nxt_high) ? ST_HIGH : ST_LOW;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            ST_HIGH: pwm_out = 1'b1;
            default: pwm_out = 1'b0;
        endcase
    end

    // R6: a zero period or zero high length never shows a high output
    a_r6_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((act_period == '0) || (act_high == '0)) |-> !pwm_out);

    // R7: a cleared enable forces the output low on the next cycle
    a_r7_disable_low: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !pwm_out);

    // R4: high only in the opening ticks of the period
    a_r4_high_in_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIGH) |-> (cnt_q < act_high));

    // R4: the tick count stays inside the period
    a_r4_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt_q < act_period));
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer #(
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned CNT_W   = 10,
    parameter int unsigned EXP_MAX = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              pwm_out
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned EXP_W = $clog2(EXP_MAX + 1);

    logic             enable, running, boundary, tick;
    logic [CNT_W-1:0] act_period, act_high, nxt_period, nxt_high;
    logic [EXP_W-1:0] act_exp;

    pwm_timer_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .EXP_MAX(EXP_MAX)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .running    (running),
        .boundary   (boundary),
        .enable     (enable),
        .act_period (act_period),
        .act_high   (act_high),
        .act_exp    (act_exp),
        .nxt_period (nxt_period),
        .nxt_high   (nxt_high)
    );

    pwm_timer_prescaler #(.EXP_MAX(EXP_MAX)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (running),
        .exp_sel (act_exp),
        .tick    (tick)
    );

    pwm_timer_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .tick       (tick),
        .act_period (act_period),
        .act_high   (act_high),
        .nxt_period (nxt_period),
        .nxt_high   (nxt_high),
        .running    (running),
        .boundary   (boundary),
        .pwm_out    (pwm_out)
    );
endmodule

// File: tb/pwm_timer_test.sv
module pwm_timer_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [3:0] A_CTRL = 4'h0;
    localparam logic [3:0] A_CNT  = 4'h4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    int n_checks = 0;
    int n_err = 0;

    always #2 clk = ~clk;   // 250 MHz

    pwm_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ctrl_word(input int en, input int hold, input int e);
        return (32'(e & 1) << 15) | (32'(e >> 1) << 16) | (32'(hold) << 11) | 32'(en);
    endfunction

    function automatic logic [31:0] cnt_word(input int p, input int q);
        return (32'(p) << 16) | 32'(q);
    endfunction

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Skip any current high run, then time the next high and low runs
    task automatic measure(output int hi, output int lo);
        int g;
        hi = 0; lo = 0;
        g = 0; while (pwm_out && g < 5000) begin g++; @(negedge clk); end
        g = 0; while (!pwm_out && g < 5000) begin g++; @(negedge clk); end
        while (pwm_out && hi < 5000) begin hi++; @(negedge clk); end
        while (!pwm_out && lo < 5000) begin lo++; @(negedge clk); end
    endtask

    // Count high samples over n cycles
    task automatic count_high(input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out) highs++;
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        int hi, lo, highs, g;

        repeat (3) @(negedge clk);
        // R1: reset state
        bus_read(A_CTRL, rd); check("R1 ctrl reset", rd, 32'h0);
        bus_read(A_CNT, rd);  check("R1 count reset", rd, 32'h0);
        check("R1 output reset", 32'(pwm_out), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: control layout and readback; count still zero so R6 applies
        bus_write(A_CTRL, 32'hFFFF_FFFF);
        bus_read(A_CTRL, rd); check("R2 ctrl readback", rd, 32'h000F_8811);
        count_high(30, highs); check("R6 enabled with zero count stays low", 32'(highs), 32'h0);

        // R3: count layout and readback
        bus_write(A_CTRL, 32'h0);
        bus_write(A_CNT, 32'hFFFF_FFFF);
        bus_read(A_CNT, rd); check("R3 count readback", rd, 32'h03FF_03FF);

        // R6: zero period, then zero high length
        bus_write(A_CNT, cnt_word(0, 5));
        bus_write(A_CTRL, ctrl_word(1, 0, 0));
        count_high(30, highs); check("R6 zero period low", 32'(highs), 32'h0);
        bus_write(A_CNT, cnt_word(5, 0));
        count_high(30, highs); check("R6 zero high length low", 32'(highs), 32'h0);
        bus_write(A_CTRL, 32'h0);

        // R10: unmapped offsets
        bus_write(4'h8, 32'hFFFF_FFFF);
        bus_write(4'hC, 32'hFFFF_FFFF);
        bus_read(4'h8, rd);   check("R10 unmapped read", rd, 32'h0);
        bus_read(A_CTRL, rd); check("R10 ctrl untouched", rd, 32'h0);
        bus_read(A_CNT, rd);  check("R10 count untouched", rd, cnt_word(5, 0));
        count_high(20, highs); check("R10 output untouched", 32'(highs), 32'h0);

        // R4, R5, R7: sweep of exponent, period and high length from a fresh start
        for (int e = 0; e < 3; e++) begin
            for (int p = 1; p <= 5; p++) begin
                for (int q = 1; q <= 6; q++) begin
                    bus_write(A_CTRL, 32'h0);
                    bus_write(A_CNT, cnt_word(p, q));
                    bus_write(A_CTRL, ctrl_word(1, 0, e));
                    if (q < p) begin
                        measure(hi, lo);
                        check($sformatf("R4 R7 high e=%0d p=%0d q=%0d", e, p, q), 32'(hi), 32'(q << e));
                        check($sformatf("R4 low e=%0d p=%0d q=%0d", e, p, q), 32'(lo), 32'((p - q) << e));
                    end else begin
                        g = 0; while (!pwm_out && g < 100) begin g++; @(negedge clk); end
                        count_high(3 * (p << e), highs);
                        check($sformatf("R5 always high e=%0d p=%0d q=%0d", e, p, q), 32'(highs), 32'(3 * (p << e)));
                    end
                end
            end
        end

        // R7: disable while high
        bus_write(A_CTRL, 32'h0);
        bus_write(A_CNT, cnt_word(8, 6));
        bus_write(A_CTRL, ctrl_word(1, 0, 0));
        g = 0; while (!pwm_out && g < 100) begin g++; @(negedge clk); end
        bus_write(A_CTRL, 32'h0);
        @(negedge clk);
        check("R7 low after disable", 32'(pwm_out), 32'h0);
        count_high(20, highs); check("R7 stays low", 32'(highs), 32'h0);

        // R8: hold bit defers a new count until it is cleared
        bus_write(A_CNT, cnt_word(4, 1));
        bus_write(A_CTRL, ctrl_word(1, 0, 1));
        measure(hi, lo);
        check("R8 base high", 32'(hi), 32'd2);
        bus_write(A_CTRL, ctrl_word(1, 1, 1));
        bus_write(A_CNT, cnt_word(6, 4));
        bus_write(A_CTRL, ctrl_word(1, 1, 2));
        bus_read(A_CNT, rd); check("R8 held count reads back", rd, cnt_word(6, 4));
        repeat (20) @(negedge clk);
        measure(hi, lo);
        check("R8 held high unchanged", 32'(hi), 32'd2);
        check("R8 held low unchanged", 32'(lo), 32'd6);
        bus_write(A_CTRL, ctrl_word(1, 0, 2));
        measure(hi, lo);
        check("R8 released high", 32'(hi), 32'd16);
        check("R8 released low", 32'(lo), 32'd8);

        // R9: unheld write mid-period waits for the period end
        bus_write(A_CTRL, 32'h0);
        bus_write(A_CNT, cnt_word(5, 3));
        bus_write(A_CTRL, ctrl_word(1, 0, 2));
        g = 0; while (!pwm_out && g < 100) begin g++; @(negedge clk); end
        hi = 1;
        bus_write(A_CNT, cnt_word(5, 1));
        while (pwm_out && hi < 5000) begin hi++; @(negedge clk); end
        lo = 0;
        while (!pwm_out && lo < 5000) begin lo++; @(negedge clk); end
        check("R9 current high finishes", 32'(hi), 32'd12);
        check("R9 current low finishes", 32'(lo), 32'd8);
        hi = 0;
        while (pwm_out && hi < 5000) begin hi++; @(negedge clk); end
        check("R9 next period uses new high", 32'(hi), 32'd4);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule